// File: doc/BRIEF.md
# Bridge Function Configuration Header with I/O Forwarding Window

This block is the configuration register file for one function of a PCI-to-PCI bridge. Configuration software reaches it through a simple access port: a dword offset, four byte enables, write data, a write strobe and a read strobe. Read data is registered. The block holds the identification words, the cache line size, the primary and secondary latency timer values, the three bus numbers, and the I/O window bounds. Each bound has a writable nibble for address bits 15:12 and its own 16-bit extension for address bits 31:16.

The stored window drives a combinational decision. For any 32-bit I/O address presented at the block, it reports whether the address lies inside the bridge's forwarding range. The range has 4 KB granularity and includes both of its end points. A parameter selects whether the block serves function 0 or function 1 of the bridge, and the header type follows that choice. The block does not implement the bus protocol, the latency counters or the memory windows.

Top module: `bcfg_top`

## Requirements
- R1: After reset every writable field reads 0. Reads then return 0604_0001h at dword 2 (byte offset 08h), the header type alone at dword 3 (0Ch), 0 at dword 6 (18h), 0000_0101h at dword 7 (1Ch) and 0 at dword 12 (30h).
- R2: The word at offset 08h always reads 0604_0001h, with the class code in bits 31:8 and the revision in bits 7:0. Writes to it have no effect.
- R3: Bits 23:16 of offset 0Ch read 81h when FUNC_NUM is 0 and 01h when FUNC_NUM is 1, and no write changes them. Bits 31:24 of offset 0Ch read 0.
- R4: The cache line size is in bits 7:0 of offset 0Ch. A write with byte enable 0 set stores the value only when it is 00h, 01h, 02h, 04h, 08h or 10h. Any other value is ignored, and the old contents stay.
- R5: At offset 18h, bits 7:0 hold the primary bus number, bits 15:8 the secondary bus number, bits 23:16 the subordinate bus number and bits 31:24 the secondary latency timer. Byte lane n is written only when byte enable n is set.
- R6: The primary latency timer is in bits 15:8 of offset 0Ch. It is read/write and is written only when byte enable 1 is set.
- R7: At offset 1Ch, bits 7:4 hold the I/O base nibble (address bits 15:12) and bits 15:12 hold the I/O limit nibble. Bits 3:0 and bits 11:8 always read 0001b. Bits 31:16 read 0.
- R8: At offset 30h, bits 15:0 hold the base address bits 31:16 and bits 31:16 hold the limit address bits 31:16. Both are read/write, written per byte lane.
- R9: io_fwd is 1 exactly when {base_upper, base_nibble, 000h} <= io_addr <= {limit_upper, limit_nibble, FFFh}. It follows io_addr and the stored registers with no clock delay.
- R10: When the base exceeds the limit, io_fwd is 0 for every address.
- R11: cfg_rdata takes the addressed word on the clock edge that samples cfg_rd and holds it until the next read. An offset outside the map reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_off | input | 6 | Dword offset of the access |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_wr | input | 1 | Write strobe, one cycle per write |
| cfg_rd | input | 1 | Read strobe, one cycle per read |
| cfg_rdata | output | 32 | Registered read data |
| io_addr | input | 32 | I/O address to classify |
| io_fwd | output | 1 | Address lies inside the I/O forwarding window |

## Verification
A write takes effect on the edge that samples cfg_wr. A read issued in the following cycle therefore returns the new value. The read word appears on cfg_rdata one edge after cfg_rd is sampled, so the scoreboard monitor waits for the edge that sees the strobe and compares on the next falling edge. io_fwd has no clock delay. The bench changes io_addr only after any pending write has committed, waits a short settle time and compares within the same cycle. Hold behaviour is checked at the port by leaving cfg_rdata idle across several edges and across a write.

// File: rtl/bcfg_pkg.sv
package bcfg_pkg;

    localparam int DATA_W  = 32;
    localparam int BE_W    = DATA_W / 8;
    localparam int IOA_W   = 32;
    localparam int GRAN_W  = 12;
    localparam int UP_W    = 16;

    // dword indices of the mapped words
    localparam int DW_IDENT = 2;
    localparam int DW_MISC  = 3;
    localparam int DW_BUS   = 6;
    localparam int DW_IOWIN = 7;
    localparam int DW_IOUP  = 12;

    localparam logic [7:0]  REV_ID_VAL   = 8'h01;
    localparam logic [23:0] CLASS_VAL    = 24'h060400;
    localparam logic [3:0]  IO32_CODE    = 4'b0001;
    localparam logic [7:0]  CLS_MAX      = 8'h10;

    typedef struct packed {
        logic [7:0]            cls;
        logic [7:0]            plat;
        logic [BE_W-1:0][7:0]  bus;     // pbus, sbus, subus, slat
        logic [3:0]            io_bnib;
        logic [3:0]            io_lnib;
        logic [BE_W-1:0][7:0]  ioup;    // base[15:0] low half, limit high half
    } cfg_state_t;

    typedef struct packed {
        logic [UP_W-1:0] up;
        logic [3:0]      nib;
    } io_bound_t;

    function automatic logic cls_legal(input logic [7:0] v);
        return ((v & (v - 8'd1)) == 8'd0) && (v <= CLS_MAX);
    endfunction

    function automatic logic [7:0] lane_merge(input logic [7:0] old_v,
                                              input logic [7:0] new_v,
                                              input logic en);
        return en ? new_v : old_v;
    endfunction

    function automatic logic [7:0] hdr_for(input int fn);
        return (fn == 0) ? 8'h81 : 8'h01;
    endfunction

endpackage

// File: rtl/bcfg_regs.sv
module bcfg_regs
    import bcfg_pkg::*;
#(
    parameter int OFF_W = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic [OFF_W-1:0]    off,
    input  logic [BE_W-1:0]     be,
    input  logic [DATA_W-1:0]   wdata,
    output cfg_state_t          st
);

    localparam logic [OFF_W-1:0] O_MISC  = OFF_W'(DW_MISC);
    localparam logic [OFF_W-1:0] O_BUS   = OFF_W'(DW_BUS);
    localparam logic [OFF_W-1:0] O_IOWIN = OFF_W'(DW_IOWIN);
    localparam logic [OFF_W-1:0] O_IOUP  = OFF_W'(DW_IOUP);

    cfg_state_t q;
    logic [BE_W-1:0][7:0] wbytes;

    assign wbytes = wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (wr) begin
            if (off == O_MISC) begin
                if (be[0] && cls_legal(wbytes[0]))
                    q.cls <= wbytes[0];
                q.plat <= lane_merge(q.plat, wbytes[1], be[1]);
            end
            if (off == O_BUS) begin
                for (int i = 0; i < BE_W; i++)
                    q.bus[i] <= lane_merge(q.bus[i], wbytes[i], be[i]);
            end
            if (off == O_IOWIN) begin
                if (be[0]) q.io_bnib <= wbytes[0][7:4];
                if (be[1]) q.io_lnib <= wbytes[1][7:4];
            end
            if (off == O_IOUP) begin
                for (int i = 0; i < BE_W; i++)
                    q.ioup[i] <= lane_merge(q.ioup[i], wbytes[i], be[i]);
            end
        end
    end

    assign st = q;

endmodule

// File: rtl/bcfg_rdmux.sv
module bcfg_rdmux
    import bcfg_pkg::*;
#(
    parameter int OFF_W    = 6,
    parameter int FUNC_NUM = 0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rd,
    input  logic [OFF_W-1:0]    off,
    input  cfg_state_t          st,
    output logic [DATA_W-1:0]   rdata
);

    localparam logic [OFF_W-1:0] O_IDENT = OFF_W'(DW_IDENT);
    localparam logic [OFF_W-1:0] O_MISC  = OFF_W'(DW_MISC);
    localparam logic [OFF_W-1:0] O_BUS   = OFF_W'(DW_BUS);
    localparam logic [OFF_W-1:0] O_IOWIN = OFF_W'(DW_IOWIN);
    localparam logic [OFF_W-1:0] O_IOUP  = OFF_W'(DW_IOUP);

    logic [7:0]        hdr;
    logic [DATA_W-1:0] word;
    logic [DATA_W-1:0] rdata_q;

    generate
        if (FUNC_NUM == 0) begin : g_fn0
            assign hdr = hdr_for(0);
        end else begin : g_fn1
            assign hdr = hdr_for(1);
        end
    endgenerate

    always_comb begin
        word = '0;
        unique case (off)
            O_IDENT: word = {CLASS_VAL, REV_ID_VAL};
            O_MISC:  word = {8'h00, hdr, st.plat, st.cls};
            O_BUS:   word = st.bus;
            O_IOWIN: word = {16'h0000, st.io_lnib, IO32_CODE, st.io_bnib, IO32_CODE};
            O_IOUP:  word = st.ioup;
            default: word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (rd)
            rdata_q <= word;
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/bcfg_iowin.sv
module bcfg_iowin
    import bcfg_pkg::*;
(
    input  io_bound_t           lo,
    input  io_bound_t           hi,
    input  logic [IOA_W-1:0]    addr,
    output logic                hit
);

    logic [IOA_W-1:0] lo_addr;
    logic [IOA_W-1:0] hi_addr;

    assign lo_addr = {lo, {GRAN_W{1'b0}}};
    assign hi_addr = {hi, {GRAN_W{1'b1}}};
    assign hit     = (addr >= lo_addr) && (addr <= hi_addr);

endmodule

// File: rtl/bcfg_top.sv
module bcfg_top
    import bcfg_pkg::*;
#(
    parameter int OFF_W    = 6,
    parameter int FUNC_NUM = 0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [OFF_W-1:0]    cfg_off,
    input  logic [BE_W-1:0]     cfg_be,
    input  logic [DATA_W-1:0]   cfg_wdata,
    input  logic                cfg_wr,
    input  logic                cfg_rd,
    output logic [DATA_W-1:0]   cfg_rdata,
    input  logic [IOA_W-1:0]    io_addr,
    output logic                io_fwd
);

    cfg_state_t st;
    io_bound_t  win_lo;
    io_bound_t  win_hi;

    bcfg_regs #(.OFF_W(OFF_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (cfg_wr),
        .off   (cfg_off),
        .be    (cfg_be),
        .wdata (cfg_wdata),
        .st    (st)
    );

    bcfg_rdmux #(.OFF_W(OFF_W), .FUNC_NUM(FUNC_NUM)) u_rdmux (
        .clk   (clk),
        .rst   (rst),
        .rd    (cfg_rd),
        .off   (cfg_off),
        .st    (st),
        .rdata (cfg_rdata)
    );

    assign win_lo = '{up: {st.ioup[1], st.ioup[0]}, nib: st.io_bnib};
    assign win_hi = '{up: {st.ioup[3], st.ioup[2]}, nib: st.io_lnib};

    bcfg_iowin u_iowin (
        .lo   (win_lo),
        .hi   (win_hi),
        .addr (io_addr),
        .hit  (io_fwd)
    );

endmodule

// File: rtl/bcfg_chk.sv
module bcfg_chk
    import bcfg_pkg::*;
#(
    parameter int OFF_W    = 6,
    parameter int FUNC_NUM = 0
) (
    input logic                clk,
    input logic                rst,
    input logic                cfg_rd,
    input logic [OFF_W-1:0]    cfg_off,
    input logic [DATA_W-1:0]   cfg_rdata,
    input logic [IOA_W-1:0]    io_addr,
    input logic                io_fwd,
    input io_bound_t           win_lo,
    input io_bound_t           win_hi
);

    localparam logic [7:0] HDR_EXP = (FUNC_NUM == 0) ? 8'h81 : 8'h01;

    AST_IDENT_FIXED: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_rd) && !$past(rst) && $past(cfg_off) == OFF_W'(DW_IDENT))
        |-> cfg_rdata == 32'h0604_0001); // R2

    AST_HDR_FIXED: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_rd) && !$past(rst) && $past(cfg_off) == OFF_W'(DW_MISC))
        |-> (cfg_rdata[23:16] == HDR_EXP && cfg_rdata[31:24] == 8'h00)); // R3

    AST_CLS_LEGAL: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_rd) && !$past(rst) && $past(cfg_off) == OFF_W'(DW_MISC))
        |-> ($onehot0(cfg_rdata[7:0]) && cfg_rdata[7:0] <= 8'h10)); // R4

    AST_IO_NIBBLES: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_rd) && !$past(rst) && $past(cfg_off) == OFF_W'(DW_IOWIN))
        |-> (cfg_rdata[3:0] == 4'b0001 && cfg_rdata[11:8] == 4'b0001)); // R7

    AST_FWD_INSIDE: assert property (@(posedge clk) disable iff (rst)
        io_fwd |-> (io_addr[IOA_W-1:GRAN_W] >= win_lo && io_addr[IOA_W-1:GRAN_W] <= win_hi)); // R9

    AST_FWD_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (win_lo > win_hi) |-> !io_fwd); // R10

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(cfg_rd) && !$past(rst)) |-> $stable(cfg_rdata)); // R11

endmodule

bind bcfg_top bcfg_chk #(.OFF_W(OFF_W), .FUNC_NUM(FUNC_NUM)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_rd    (cfg_rd),
    .cfg_off   (cfg_off),
    .cfg_rdata (cfg_rdata),
    .io_addr   (io_addr),
    .io_fwd    (io_fwd),
    .win_lo    (win_lo),
    .win_hi    (win_hi)
);

// File: tb/bcfg_top_bench.sv
module bcfg_top_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  cfg_off = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_wr = 1'b0;
    logic        cfg_rd = 1'b0;
    logic [31:0] cfg_rdata;
    logic [31:0] io_addr = '0;
    logic        io_fwd;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;   // 50 MHz

    bcfg_top #(.OFF_W(6), .FUNC_NUM(0)) u_bcfg_top (
        .clk       (clk),
        .rst       (rst),
        .cfg_off   (cfg_off),
        .cfg_be    (cfg_be),
        .cfg_wdata (cfg_wdata),
        .cfg_wr    (cfg_wr),
        .cfg_rd    (cfg_rd),
        .cfg_rdata (cfg_rdata),
        .io_addr   (io_addr),
        .io_fwd    (io_fwd)
    );

    task automatic cfg_write(input logic [5:0] off, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_off = off; cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0;
    endtask

    task automatic cfg_read(input logic [5:0] off, input logic [31:0] exp, input string tag);
        @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        cfg_off = off; cfg_rd = 1'b1;
        @(negedge clk);
        cfg_rd = 1'b0;
    endtask

    task automatic fwd_check(input logic [31:0] a, input logic exp, input string tag);
        @(negedge clk);
        io_addr = a;
        #1;
        n_chk++;
        if (io_fwd !== exp) begin
            n_fail++;
            $display("FAIL %s io_fwd addr=%h actual=%b expected=%b", tag, a, io_fwd, exp);
        end
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(posedge clk);
            if (cfg_rd && !rst) begin
                @(negedge clk);
                begin
                    logic [31:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    n_chk++;
                    if (cfg_rdata !== e) begin
                        n_fail++;
                        $display("FAIL %s rdata actual=%h expected=%h", t, cfg_rdata, e);
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state, R3 header type
        cfg_read(6'd2,  32'h0604_0001, "R1 ident");
        cfg_read(6'd3,  32'h0081_0000, "R1 R3 misc");
        cfg_read(6'd6,  32'h0000_0000, "R1 bus");
        cfg_read(6'd7,  32'h0000_0101, "R1 iowin");
        cfg_read(6'd12, 32'h0000_0000, "R1 ioup");
        cfg_read(6'd1,  32'h0000_0000, "R11 unmapped");

        // R2 read-only ident
        cfg_write(6'd2, 4'hF, 32'hFFFF_FFFF);
        cfg_read(6'd2, 32'h0604_0001, "R2 ident after write");

        // R3 R4 R6: illegal cls ignored, plat written, header kept
        cfg_write(6'd3, 4'hF, 32'hFFFF_FFFF);
        cfg_read(6'd3, 32'h0081_FF00, "R3 R4 R6 misc all ones");
        cfg_write(6'd3, 4'h1, 32'h0000_0010);
        cfg_read(6'd3, 32'h0081_FF10, "R4 cls 10h");
        cfg_write(6'd3, 4'h1, 32'h0000_0003);
        cfg_read(6'd3, 32'h0081_FF10, "R4 cls 03h ignored");
        cfg_write(6'd3, 4'h1, 32'h0000_0020);
        cfg_read(6'd3, 32'h0081_FF10, "R4 cls 20h ignored");
        cfg_write(6'd3, 4'h2, 32'h0000_0004);
        cfg_read(6'd3, 32'h0081_0010, "R6 plat lane only");
        cfg_write(6'd3, 4'h1, 32'h0000_0000);
        cfg_read(6'd3, 32'h0081_0000, "R4 cls 00h");

        // R5 bus lanes
        cfg_write(6'd6, 4'b0101, 32'h4433_2211);
        cfg_read(6'd6, 32'h0033_0011, "R5 lanes 0 2");
        cfg_write(6'd6, 4'b1010, 32'hAABB_CCDD);
        cfg_read(6'd6, 32'hAA33_CC11, "R5 lanes 1 3");

        // R7 io nibbles
        cfg_write(6'd7, 4'hF, 32'hFFFF_3F2E);
        cfg_read(6'd7, 32'h0000_3121, "R7 nibbles");

        // R8 upper halves
        cfg_write(6'd12, 4'hF, 32'h0001_0001);
        cfg_read(6'd12, 32'h0001_0001, "R8 upper");

        // R9 window 0001_2000 .. 0001_3FFF
        fwd_check(32'h0001_2000, 1'b1, "R9 low edge");
        fwd_check(32'h0001_1FFF, 1'b0, "R9 below");
        fwd_check(32'h0001_3FFF, 1'b1, "R9 high edge");
        fwd_check(32'h0001_4000, 1'b0, "R9 above");
        fwd_check(32'h0000_2500, 1'b0, "R9 upper mismatch");

        // R10 base above limit
        cfg_write(6'd7, 4'h3, 32'h0000_4050);
        fwd_check(32'h0001_4800, 1'b0, "R10 empty a");
        fwd_check(32'h0001_5000, 1'b0, "R10 empty b");

        // R9 single 4 KB page
        cfg_write(6'd7, 4'h3, 32'h0000_5050);
        fwd_check(32'h0001_5ABC, 1'b1, "R9 single page");
        fwd_check(32'h0001_6000, 1'b0, "R9 single page above");

        // R11 hold across idle cycles and a write
        cfg_read(6'd7, 32'h0000_5151, "R11 last read");
        @(negedge clk);
        held = cfg_rdata;
        cfg_write(6'd6, 4'hF, 32'h1234_5678);
        repeat (3) @(negedge clk);
        n_chk++;
        if (cfg_rdata !== held) begin
            n_fail++;
            $display("FAIL R11 hold actual=%h expected=%h", cfg_rdata, held);
        end
        cfg_read(6'd6, 32'h1234_5678, "R5 R11 read after write");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule